// File: doc/BRIEF.md
# Serial Memory Write-Protect Arbiter

This block sits beside the byte-write path of a 64K-byte serial nonvolatile memory and rules on every write the bus engine presents. It keeps the protection control byte, which lives at the very top of the address space, and answers each write request one cycle later with either a grant or a deny pulse. It does not store array data or time the programming. It only tells the engine whether the byte may be committed, and it updates the control byte itself when that byte is the target.

Three layers of protection feed one decision. The first is a volatile software enable bit, which must be set before any nonvolatile write. The second is a 3-bit block-protect code that fences off a top-aligned slice of the array. The third is a hardware-protect enable bit. When that bit is combined with the write-protect pin level, which is captured at START, it freezes the control byte.

A two-state bus tracker follows the transaction. `S_IDLE` moves to `S_OPEN` on a START strobe and captures the pin at that moment. `S_OPEN` stays in `S_OPEN` on a repeated START and captures the pin again. `S_OPEN` returns to `S_IDLE` on a STOP strobe, and STOP wins when both strobes arrive together. Write requests are honoured only in `S_OPEN`.

Top module: `wp_arbiter`

## Requirements
- R1: After reset, ctrl_o is 8'h00, and grant_o and deny_o are both low.
- R2: The control byte sits at address 16'hFFFF. Its layout is: bit 1 is the software enable, bits 4:2 are the block-protect code, bit 7 is the hardware-protect enable, and the other bits read 0. A write of 8'h02 to 16'hFFFF sets the enable bit and a write of 8'h01 clears it. Both commands are granted in any open transaction, whatever the protection state.
- R3: Every other write is nonvolatile. This covers any array address and any other data byte sent to 16'hFFFF. A nonvolatile write is denied while the enable bit is 0.
- R4: Block-protect code c=0 protects nothing. A code c from 1 to 7 protects array addresses at or above 65536 − (65536 >> (7−c)), which is the top 1/64, 1/32, 1/16, 1/8, 1/4, 1/2 or all of the array. A write inside a protected range is denied.
- R5: A granted nonvolatile write to 16'hFFFF loads the block-protect code from data bits 4:2 and the hardware-protect enable from data bit 7.
- R6: If the pin was high at START and the hardware-protect enable is 1, nonvolatile writes to 16'hFFFF are denied. The enable commands are still granted.
- R7: If the pin was low at START, the hardware-protect enable has no effect, and the control byte stays writable when the enable bit is set.
- R8: The pin level is taken only on a START strobe. A pin change in the middle of a transaction has no effect until the next START.
- R9: Every granted nonvolatile write, whether to the array or to the control byte, clears the enable bit.
- R10: A request gets exactly one response: grant_o or deny_o is high for the single cycle after the request cycle. A denied request leaves ctrl_o unchanged.
- R11: A request made in `S_IDLE` is denied. This covers a request before any START, a request after STOP, and a request in the same cycle as the START strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | One-cycle strobe: START seen on the bus |
| txn_end | input | 1 | One-cycle strobe: STOP seen on the bus |
| wp_pin | input | 1 | Write-protect pin level |
| wr_req | input | 1 | Write request valid for one cycle |
| wr_addr | input | ADDR_W | Target byte address |
| wr_data | input | 8 | Byte to be written |
| grant_o | output | 1 | Write may proceed (one cycle after request) |
| deny_o | output | 1 | Write refused (one cycle after request) |
| ctrl_o | output | 8 | Current control byte |

## Verification
The array sweep crosses all eight block-protect codes with the addresses just below and exactly on every region boundary. This separates an off-by-one floor from a shift by the wrong amount. A second sweep pairs both pin levels with both states of the hardware-protect enable. It shows that the lock needs both conditions and leaves the enable commands alone. Separate patterns cover a request with the enable bit clear, a pin change in mid-transaction, a request outside a transaction, and a request in the same cycle as START. These show whether protection comes from the bit, from the captured pin or from the bus state.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    // Field positions inside the control byte
    localparam int CTL_WEL  = 1;
    localparam int CTL_BPLO = 2;
    localparam int CTL_BPHI = 4;
    localparam int CTL_HPEN = 7;

    // Volatile enable-bit commands written to the top address
    localparam logic [7:0] CMD_EN_SET = 8'h02;
    localparam logic [7:0] CMD_EN_CLR = 8'h01;

    typedef enum logic [2:0] {
        K_NONE,
        K_EN_SET,
        K_EN_CLR,
        K_REG,
        K_ARRAY
    } wr_kind_e;

    typedef enum logic [0:0] {
        S_IDLE,
        S_OPEN
    } bus_state_e;

    typedef struct packed {
        logic       hpen;
        logic [2:0] bp;
        logic       wel;
    } ctl_s;

endpackage

// File: rtl/wpa_region.sv
module wpa_region #(
    parameter int ADDR_W = 16
) (
    input  logic [2:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam logic [ADDR_W:0] SPAN = {1'b1, {ADDR_W{1'b0}}};

    logic [2:0]      shift_w;
    logic [ADDR_W:0] floor_w;

    always_comb begin
        shift_w  = 3'd7 - bp_i;
        floor_w  = SPAN - (SPAN >> shift_w);
        locked_o = (bp_i != 3'd0) && ({1'b0, addr_i} >= floor_w);
    end
endmodule

// File: rtl/wpa_decide.sv
module wpa_decide
    import wpa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              req_i,
    input  logic              in_txn_i,
    input  logic              wp_lat_i,
    input  ctl_s              ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output wr_kind_e          kind_o,
    output logic              allow_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    logic region_locked;

    wpa_region #(.ADDR_W(ADDR_W)) u_region (
        .bp_i     (ctl_i.bp),
        .addr_i   (addr_i),
        .locked_o (region_locked)
    );

    always_comb begin
        kind_o  = K_NONE;
        allow_o = 1'b0;
        if (req_i) begin
            if (addr_i == TOP) begin
                unique case (data_i)
                    CMD_EN_SET: kind_o = K_EN_SET;
                    CMD_EN_CLR: kind_o = K_EN_CLR;
                    default:    kind_o = K_REG;
                endcase
            end else begin
                kind_o = K_ARRAY;
            end
            unique case (kind_o)
                K_EN_SET, K_EN_CLR: allow_o = in_txn_i;
                K_REG:   allow_o = in_txn_i && ctl_i.wel && !(wp_lat_i && ctl_i.hpen);
                K_ARRAY: allow_o = in_txn_i && ctl_i.wel && !region_locked;
                default: allow_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wpa_ctl_reg.sv
module wpa_ctl_reg
    import wpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit_i,
    input  wr_kind_e   kind_i,
    input  logic [7:0] data_i,
    output ctl_s       ctl_o
);
    ctl_s ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (commit_i) begin
            unique case (kind_i)
                K_EN_SET: ctl_q.wel <= 1'b1;
                K_EN_CLR: ctl_q.wel <= 1'b0;
                K_REG: begin
                    ctl_q.bp   <= data_i[CTL_BPHI:CTL_BPLO];
                    ctl_q.hpen <= data_i[CTL_HPEN];
                    ctl_q.wel  <= 1'b0;
                end
                K_ARRAY: ctl_q.wel <= 1'b0;
                default: ctl_q <= ctl_q;
            endcase
        end
    end

    assign ctl_o = ctl_q;

    // R9
    nv_commit_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (kind_i == K_REG || kind_i == K_ARRAY)) |=> !ctl_q.wel);
endmodule

// File: rtl/wp_arbiter.sv
module wp_arbiter
    import wpa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_end,
    input  logic              wp_pin,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              grant_o,
    output logic              deny_o,
    output logic [7:0]        ctrl_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    bus_state_e state_q, state_d;
    logic       wp_lat_q;
    logic       grant_q, deny_q;
    ctl_s       ctl;
    wr_kind_e   kind;
    logic       allow;

    // Bus tracker state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (txn_start) state_d = S_OPEN;
            S_OPEN: if (txn_end)   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    wpa_decide #(.ADDR_W(ADDR_W)) u_decide (
        .req_i    (wr_req),
        .in_txn_i (state_q == S_OPEN),
        .wp_lat_i (wp_lat_q),
        .ctl_i    (ctl),
        .addr_i   (wr_addr),
        .data_i   (wr_data),
        .kind_o   (kind),
        .allow_o  (allow)
    );

    wpa_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (allow),
        .kind_i   (kind),
        .data_i   (wr_data),
        .ctl_o    (ctl)
    );

    // Output and pin-capture process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_lat_q <= 1'b0;
            grant_q  <= 1'b0;
            deny_q   <= 1'b0;
        end else begin
            if (txn_start) wp_lat_q <= wp_pin;
            grant_q <= wr_req && allow;
            deny_q  <= wr_req && !allow;
        end
    end

    assign grant_o = grant_q;
    assign deny_o  = deny_q;
    assign ctrl_o  = {ctl.hpen, 2'b00, ctl.bp, ctl.wel, 1'b0};

    // R10
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    // R10
    response_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || deny_o) |-> $past(wr_req));

    // R10
    deny_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> (ctrl_o == $past(ctrl_o)));

    // R3
    nv_grant_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !($past(wr_addr) == TOP &&
                      ($past(wr_data) == CMD_EN_SET || $past(wr_data) == CMD_EN_CLR)))
        |-> $past(ctrl_o[CTL_WEL]));

    // R5
    prot_bits_move_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[7:2] != $past(ctrl_o[7:2])) |-> grant_o);

    // R11
    idle_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && state_q == S_IDLE) |=> deny_o);
endmodule

// File: tb/wp_arbiter_test.sv
`timescale 1ns/1ps
module wp_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0, txn_end = 1'b0, wp_pin = 1'b0, wr_req = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        grant_o, deny_o;
    logic [7:0]  ctrl_o;

    int checks = 0;
    int errors = 0;

    // Reference state, kept from the requirements
    logic       m_wel = 0, m_hpen = 0, m_open = 0, m_wp = 0;
    logic [2:0] m_bp = 0;

    always #5 clk = ~clk;

    wp_arbiter #(.ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
        .wp_pin(wp_pin), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .grant_o(grant_o), .deny_o(deny_o), .ctrl_o(ctrl_o)
    );

    function automatic logic [7:0] m_ctrl();
        return {m_hpen, 2'b00, m_bp, m_wel, 1'b0};
    endfunction

    function automatic int floor_of(input int c);
        return 65536 - (65536 >> (7 - c));
    endfunction

    task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start(input logic w);
        @(negedge clk); txn_start = 1'b1; wp_pin = w;
        @(negedge clk); txn_start = 1'b0;
        m_open = 1'b1; m_wp = w;
    endtask

    task automatic bus_stop();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
        m_open = 1'b0;
    endtask

    task automatic req(input logic [15:0] a, input logic [7:0] d, input string ovr);
        logic  eg;
        string tag;
        eg = 1'b0;
        if (!m_open) begin
            tag = "R11";
        end else if (a == 16'hFFFF && d == 8'h02) begin
            eg = 1; tag = "R2"; m_wel = 1;
        end else if (a == 16'hFFFF && d == 8'h01) begin
            eg = 1; tag = "R2"; m_wel = 0;
        end else if (a == 16'hFFFF) begin
            if (!m_wel) tag = "R3";
            else if (m_wp && m_hpen) tag = "R6";
            else begin
                eg = 1; tag = m_hpen ? "R7" : "R5";
                m_bp = d[4:2]; m_hpen = d[7]; m_wel = 0;
            end
        end else begin
            if (!m_wel) tag = "R3";
            else if (m_bp != 0 && int'(a) >= floor_of(int'(m_bp))) tag = "R4";
            else begin eg = 1; tag = "R9"; m_wel = 0; end
        end
        if (ovr != "") tag = ovr;
        @(negedge clk); wr_req = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_req = 1'b0;
        check(tag, grant_o == eg && deny_o == !eg,
              {14'd0, grant_o, deny_o}, {14'd0, eg, !eg});
        check(tag, ctrl_o == m_ctrl(), {8'd0, ctrl_o}, {8'd0, m_ctrl()});
        @(negedge clk);
        // R10: response lasts one cycle
        check("R10", !grant_o && !deny_o, {14'd0, grant_o, deny_o}, 16'd0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", ctrl_o == 8'h00 && !grant_o && !deny_o, {8'd0, ctrl_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ctrl_o == 8'h00 && !grant_o && !deny_o, {8'd0, ctrl_o}, 16'd0);

        // R11: outside any transaction
        req(16'h0000, 8'h02, "R11");
        req(16'h1234, 8'h55, "R11");

        // R11: request in the START strobe cycle
        @(negedge clk); txn_start = 1'b1; wp_pin = 1'b0; wr_req = 1'b1;
        wr_addr = 16'hFFFF; wr_data = 8'h02;
        @(negedge clk); txn_start = 1'b0; wr_req = 1'b0;
        m_open = 1; m_wp = 0;
        check("R11", deny_o && !grant_o && ctrl_o == m_ctrl(), {8'd0, ctrl_o}, {8'd0, m_ctrl()});
        bus_stop();

        // R3: nonvolatile writes without enable
        bus_start(1'b0);
        req(16'h0010, 8'hAA, "R3");
        req(16'hFFFF, 8'h1C, "R3");
        req(16'hFFFF, 8'h02, "R2");
        req(16'hFFFF, 8'h01, "R2");
        req(16'h0010, 8'hAA, "R3");
        bus_stop();

        // R4: every code against every region boundary
        for (int c = 0; c < 8; c++) begin
            bus_start(1'b0);
            req(16'hFFFF, 8'h02, "");
            req(16'hFFFF, 8'(c << 2), "R5");
            for (int b = 1; b < 8; b++) begin
                for (int off = -1; off <= 0; off++) begin
                    int a = floor_of(b) + off;
                    if (a >= 0) begin
                        req(16'hFFFF, 8'h02, "");
                        req(16'(a), 8'h5A, "");
                    end
                end
            end
            req(16'hFFFE, 8'h00, "");
            req(16'hFFFF, 8'h02, "");
            req(16'hFFFE, 8'h00, "");
            bus_stop();
        end

        // R6/R7: pin level crossed with hardware-protect enable
        for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 2; w++) begin
                bus_start(1'b0);
                req(16'hFFFF, 8'h02, "");
                req(16'hFFFF, 8'(h << 7) | 8'h08, "");
                bus_stop();
                bus_start(1'(w));
                req(16'hFFFF, 8'h02, "R6");
                req(16'hFFFF, 8'(h << 7) | 8'h10, "");
                req(16'hFFFF, 8'h01, "R6");
                bus_stop();
            end
        end

        // R8: pin change in mid-transaction is ignored
        bus_start(1'b0);
        req(16'hFFFF, 8'h02, "");
        req(16'hFFFF, 8'h80, "R5");
        bus_stop();
        bus_start(1'b0);
        @(negedge clk); wp_pin = 1'b1;
        req(16'hFFFF, 8'h02, "R8");
        req(16'hFFFF, 8'h84, "R8");
        bus_stop();
        bus_start(1'b1);
        req(16'hFFFF, 8'h02, "");
        @(negedge clk); wp_pin = 1'b0;
        req(16'hFFFF, 8'h00, "R8");
        bus_stop();

        // R11: after STOP
        req(16'h0001, 8'h01, "R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule